// File: doc/BRIEF.md
# Calendar Real-Time Clock with Coherent Snapshot Reads

This block keeps calendar time in a slow crystal clock domain and exposes it to a processor bus running on an unrelated, faster clock. A prescaler divides the crystal clock into one-second ticks. Each tick advances a cascaded chain of binary counters: seconds, minutes, hours, weekday, day of month, month and a two-digit year. Month lengths follow the calendar, and February gains a day in leap years.

Software reads the time one byte per access. A read of the seconds location also loads every other readable location from one consistent copy of the live chain, so the following reads of minutes through year all belong to the same instant. Writes set single fields. Each write must be preceded by an access that opens a one-shot write gate. Writes that arrive too close together are dropped. Two pulse inputs in the crystal domain slip the time by one second forward or back at the next tick. They are intended for temperature-drift trimming by firmware.

Top module: `cal_rtc`

## Requirements
- R1: The seconds count advances by exactly one on each tick, and a tick occurs once every TICK_DIV crystal cycles. Wraps carry upward as follows: seconds 0–59 into minutes, minutes 0–59 into hours, hours 0–23 into the day. The day step moves the weekday 1..7 (7 wraps to 1) and the day of month 1..length. The day of month carries into the month 1–12, and the month carries into the year 0–99 (99 wraps to 0). With no tick and no accepted write, the time does not change.
- R2: January, March, May, July, August, October and December have 31 days. April, June, September and November have 30. February has 29 days when the year value is a multiple of 4, and 28 otherwise.
- R3: After reset the time reads 0 s, 0 min, 0 h, weekday 1, day 1, month 1, year 0, and bus_ready is low while no access is requested.
- R4: The byte addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year and 7 unlock; every value is plain binary. A read of address 0 returns the seconds from a coherent copy of the chain and loads that whole copy into the read registers. A read of addresses 1–6 returns the copy taken at the last seconds read, even if the live time has moved on. Two seconds reads with no tick between them return equal values.
- R5: Every read has exactly one wait state: bus_ready is low in the first cycle of the request and high in the second, with bus_rdata valid. A write completes in its first cycle.
- R6: A write to addresses 0–6 changes the time only when the gate is open. A write to address 7 opens the gate (its data is ignored). The gate stays open through any number of reads. It is closed by the next write to addresses 0–6, whether or not that write is accepted. A field write with the gate closed has no effect.
- R7: A field write is ignored when it arrives while the previous field write is still crossing to the crystal domain, or less than MIN_GAP crystal cycles after the previous accepted write.
- R8: A rising edge on inc_sec makes the next tick advance the time by two seconds, with normal carries. Any number of edges before one tick count as one correction.
- R9: A rising edge on dec_sec makes the next tick leave the time unchanged, so seconds never underflow. When both corrections are pending at a tick, the time advances by one second.
- R10: A write whose value lies outside its field's range is ignored. The ranges are seconds and minutes 0–59, hours 0–23, weekday 1–7, day 1–31, month 1–12 and year 0–99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rtc | input | 1 | Crystal-domain clock |
| clk_bus | input | 1 | Processor bus clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| inc_sec | input | 1 | Add-one-second correction, rising-edge sensitive, crystal domain |
| dec_sec | input | 1 | Remove-one-second correction, rising-edge sensitive, crystal domain |
| bus_req | input | 1 | Access request, held until bus_ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte address (0–6 time fields, 7 unlock) |
| bus_wdata | input | 8 | Write data |
| bus_ready | output | 1 | Access completes in this cycle |
| bus_rdata | output | 8 | Read data, valid while bus_ready is high on a read |

## Verification
The checker watches several properties on every clock. In the crystal domain it holds the chain steady between ticks and accepted writes, keeps every field inside its legal range, and sees no two ticks back to back. It also checks that every change of the live time raises a publish toggle toward the bus side. On the bus side it checks the single wait state of reads. Calendar carries, leap-year February, the stale contents of non-seconds registers between seconds reads, the unlock gate, write pacing and the one-shot second corrections depend on sequences of accesses and ticks. Only the bench's scenarios, checked against its behavioural calendar model, show those.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

    localparam int unsigned ADDR_W = 3;
    localparam int unsigned DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_SEC    = 3'd0;
    localparam logic [ADDR_W-1:0] A_MIN    = 3'd1;
    localparam logic [ADDR_W-1:0] A_HR     = 3'd2;
    localparam logic [ADDR_W-1:0] A_DOW    = 3'd3;
    localparam logic [ADDR_W-1:0] A_DOM    = 3'd4;
    localparam logic [ADDR_W-1:0] A_MON    = 3'd5;
    localparam logic [ADDR_W-1:0] A_YR     = 3'd6;
    localparam logic [ADDR_W-1:0] A_UNLOCK = 3'd7;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hr;
        logic [2:0] dow;
        logic [4:0] dom;
        logic [3:0] mon;
        logic [6:0] yr;
    } rtc_time_t;

    localparam rtc_time_t RTC_RESET = '{sec: 6'd0, min: 6'd0, hr: 5'd0,
                                        dow: 3'd1, dom: 5'd1, mon: 4'd1, yr: 7'd0};

    function automatic logic [4:0] month_len(logic [3:0] mon, logic [6:0] yr);
        case (mon)
            4'd2:                      return (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

    // One-second step with the full carry cascade.
    function automatic rtc_time_t rtc_advance(rtc_time_t t);
        rtc_time_t r = t;
        if (t.sec < 6'd59) begin
            r.sec = t.sec + 6'd1;
        end else begin
            r.sec = 6'd0;
            if (t.min < 6'd59) begin
                r.min = t.min + 6'd1;
            end else begin
                r.min = 6'd0;
                if (t.hr < 5'd23) begin
                    r.hr = t.hr + 5'd1;
                end else begin
                    r.hr  = 5'd0;
                    r.dow = (t.dow >= 3'd7) ? 3'd1 : t.dow + 3'd1;
                    if (t.dom < month_len(t.mon, t.yr)) begin
                        r.dom = t.dom + 5'd1;
                    end else begin
                        r.dom = 5'd1;
                        if (t.mon < 4'd12) begin
                            r.mon = t.mon + 4'd1;
                        end else begin
                            r.mon = 4'd1;
                            r.yr  = (t.yr >= 7'd99) ? 7'd0 : t.yr + 7'd1;
                        end
                    end
                end
            end
        end
        return r;
    endfunction

    function automatic logic field_ok(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] v);
        case (a)
            A_SEC, A_MIN: return v < 8'd60;
            A_HR:         return v < 8'd24;
            A_DOW:        return (v >= 8'd1) && (v <= 8'd7);
            A_DOM:        return (v >= 8'd1) && (v <= 8'd31);
            A_MON:        return (v >= 8'd1) && (v <= 8'd12);
            A_YR:         return v < 8'd100;
            default:      return 1'b0;
        endcase
    endfunction

    function automatic rtc_time_t set_field(rtc_time_t t, logic [ADDR_W-1:0] a,
                                            logic [DATA_W-1:0] v);
        rtc_time_t r = t;
        case (a)
            A_SEC:   r.sec = v[5:0];
            A_MIN:   r.min = v[5:0];
            A_HR:    r.hr  = v[4:0];
            A_DOW:   r.dow = v[2:0];
            A_DOM:   r.dom = v[4:0];
            A_MON:   r.mon = v[3:0];
            A_YR:    r.yr  = v[6:0];
            default: r = t;
        endcase
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] get_field(rtc_time_t t, logic [ADDR_W-1:0] a);
        case (a)
            A_SEC:   return {2'b0, t.sec};
            A_MIN:   return {2'b0, t.min};
            A_HR:    return {3'b0, t.hr};
            A_DOW:   return {5'b0, t.dow};
            A_DOM:   return {3'b0, t.dom};
            A_MON:   return {4'b0, t.mon};
            A_YR:    return {1'b0, t.yr};
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/cal_rtc_sync.sv
module cal_rtc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cal_rtc_core.sv
module cal_rtc_core
    import cal_rtc_pkg::*;
#(
    parameter int unsigned TICK_DIV = 32768,
    parameter int unsigned MIN_GAP  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_sec,
    input  logic              dec_sec,
    input  logic              wr_tgl_s,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output rtc_time_t         tm,
    output logic              pub_tgl,
    output logic              ack_tgl,
    output logic              tick,
    output logic              wr_apply
);
    localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int unsigned GW = $clog2(MIN_GAP + 1);
    localparam logic [PW-1:0] PRESC_LAST = PW'(TICK_DIV - 1);
    localparam logic [GW-1:0] GAP_FULL   = GW'(MIN_GAP);

    typedef struct packed {
        logic [PW-1:0] presc;
        rtc_time_t     tm;
        logic          inc_prev;
        logic          dec_prev;
        logic          inc_pend;
        logic          dec_pend;
        logic [GW-1:0] gap;
        logic          wr_seen;
        logic          ack;
        logic          pub;
    } core_s;

    core_s q, d;
    logic  wr_new;

    always_comb begin
        d      = q;
        tick   = (q.presc == PRESC_LAST);
        d.presc = tick ? '0 : q.presc + 1'b1;

        // Tick: step count is 1 + inc - dec (0, 1 or 2).
        if (tick) begin
            if (q.inc_pend || !q.dec_pend) d.tm = rtc_advance(d.tm);
            if (q.inc_pend && !q.dec_pend) d.tm = rtc_advance(d.tm);
            d.inc_pend = 1'b0;
            d.dec_pend = 1'b0;
        end

        // Corrections arm on rising edges, after the tick has consumed the old ones.
        d.inc_prev = inc_sec;
        d.dec_prev = dec_sec;
        if (inc_sec && !q.inc_prev) d.inc_pend = 1'b1;
        if (dec_sec && !q.dec_prev) d.dec_pend = 1'b1;

        // Field write from the bus domain, paced and range-checked.
        wr_new   = (wr_tgl_s != q.wr_seen);
        wr_apply = wr_new && (q.gap >= GAP_FULL) && field_ok(wr_addr, wr_data);
        if (wr_new) begin
            d.wr_seen = wr_tgl_s;
            d.ack     = wr_tgl_s;
        end
        if (wr_apply) begin
            d.tm  = set_field(d.tm, wr_addr, wr_data);
            d.gap = '0;
        end else if (q.gap < GAP_FULL) begin
            d.gap = q.gap + 1'b1;
        end

        // Announce every change of the live chain to the bus side.
        d.pub = (d.tm != q.tm) ? ~q.pub : q.pub;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.tm       <= RTC_RESET;
            q.gap      <= GAP_FULL;
        end else begin
            q <= d;
        end
    end

    assign tm      = q.tm;
    assign pub_tgl = q.pub;
    assign ack_tgl = q.ack;
endmodule

// File: rtl/cal_rtc_bus.sv
module cal_rtc_bus
    import cal_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pub_s,
    input  logic              ack_s,
    input  rtc_time_t         tm_live,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              wr_tgl,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    typedef struct packed {
        rtc_time_t         snap;
        rtc_time_t         outr;
        logic              gate;
        logic              wr_tgl;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
        logic              pub_seen;
        logic              rd_wait;
        logic [DATA_W-1:0] rdata;
    } bus_s;

    bus_s q, d;

    always_comb begin
        d     = q;
        ready = req && (we || q.rd_wait);

        // The live chain is stable once its publish toggle has been synchronized.
        if (pub_s != q.pub_seen) begin
            d.pub_seen = pub_s;
            d.snap     = tm_live;
        end

        if (req && !we && !q.rd_wait) begin
            d.rd_wait = 1'b1;
            if (addr == A_SEC) begin
                d.outr  = q.snap;
                d.rdata = get_field(q.snap, A_SEC);
            end else begin
                d.rdata = get_field(q.outr, addr);
            end
        end else begin
            d.rd_wait = 1'b0;
        end

        if (req && we) begin
            if (addr == A_UNLOCK) begin
                d.gate = 1'b1;
            end else if (q.gate) begin
                d.gate = 1'b0;
                if (q.wr_tgl == ack_s) begin
                    d.wr_addr = addr;
                    d.wr_data = wdata;
                    d.wr_tgl  = ~q.wr_tgl;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.snap <= RTC_RESET;
            q.outr <= RTC_RESET;
        end else begin
            q <= d;
        end
    end

    assign rdata   = q.rdata;
    assign wr_tgl  = q.wr_tgl;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
    import cal_rtc_pkg::*;
#(
    parameter int unsigned TICK_DIV    = 32768,
    parameter int unsigned MIN_GAP     = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_rtc,
    input  logic              clk_bus,
    input  logic              rst_n,
    input  logic              inc_sec,
    input  logic              dec_sec,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata
);
    rtc_time_t         tm_live;
    logic              pub_tgl, pub_s, ack_tgl, ack_s, wr_tgl, wr_tgl_s;
    logic              tick, wr_apply;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    cal_rtc_core #(.TICK_DIV(TICK_DIV), .MIN_GAP(MIN_GAP)) u_core (
        .clk(clk_rtc), .rst_n(rst_n), .inc_sec(inc_sec), .dec_sec(dec_sec),
        .wr_tgl_s(wr_tgl_s), .wr_addr(wr_addr), .wr_data(wr_data),
        .tm(tm_live), .pub_tgl(pub_tgl), .ack_tgl(ack_tgl),
        .tick(tick), .wr_apply(wr_apply)
    );

    cal_rtc_bus u_bus (
        .clk(clk_bus), .rst_n(rst_n), .req(bus_req), .we(bus_we),
        .addr(bus_addr), .wdata(bus_wdata), .pub_s(pub_s), .ack_s(ack_s),
        .tm_live(tm_live), .ready(bus_ready), .rdata(bus_rdata),
        .wr_tgl(wr_tgl), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    cal_rtc_sync #(.STAGES(SYNC_STAGES)) u_sync_wr (
        .clk(clk_rtc), .rst_n(rst_n), .d(wr_tgl), .q(wr_tgl_s));
    cal_rtc_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
        .clk(clk_bus), .rst_n(rst_n), .d(ack_tgl), .q(ack_s));
    cal_rtc_sync #(.STAGES(SYNC_STAGES)) u_sync_pub (
        .clk(clk_bus), .rst_n(rst_n), .d(pub_tgl), .q(pub_s));
endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk
    import cal_rtc_pkg::*;
(
    input logic      clk_rtc,
    input logic      clk_bus,
    input logic      rst_n,
    input logic      bus_req,
    input logic      bus_we,
    input logic      bus_ready,
    input logic      tick,
    input logic      wr_apply,
    input logic      pub_tgl,
    input rtc_time_t tm
);
    // R1: the chain only moves on a tick or an accepted write
    p_hold_r1: assert property (@(posedge clk_rtc) disable iff (!rst_n)
        (!tick && !wr_apply) |=> $stable(tm));

    // R1: ticks are never adjacent
    p_tick_space_r1: assert property (@(posedge clk_rtc) disable iff (!rst_n)
        tick |=> !tick);

    // R10: every field stays within its legal range
    p_range_r10: assert property (@(posedge clk_rtc) disable iff (!rst_n)
        (tm.sec < 6'd60) && (tm.min < 6'd60) && (tm.hr < 5'd24) &&
        (tm.dow >= 3'd1) && (tm.dom >= 5'd1) &&
        (tm.mon >= 4'd1) && (tm.mon <= 4'd12) && (tm.yr < 7'd100));

    // R4: any change of the live chain is announced to the bus side
    p_publish_r4: assert property (@(posedge clk_rtc) disable iff (!rst_n)
        !$stable(tm) |-> !$stable(pub_tgl));

    // R5: a read waiting in its first cycle completes in the next one
    p_wait_once_r5: assert property (@(posedge clk_bus) disable iff (!rst_n)
        (bus_req && !bus_we && !bus_ready) |=> (bus_ready || !bus_req));

    // R5: a read never completes without its wait cycle
    p_no_zero_wait_r5: assert property (@(posedge clk_bus) disable iff (!rst_n)
        (bus_req && !bus_we && bus_ready) |-> $past(bus_req && !bus_we && !bus_ready));
endmodule

bind cal_rtc cal_rtc_chk u_chk (
    .clk_rtc(clk_rtc), .clk_bus(clk_bus), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_ready(bus_ready),
    .tick(tick), .wr_apply(wr_apply), .pub_tgl(pub_tgl), .tm(tm_live)
);

// File: tb/tb_cal_rtc.sv
module tb_cal_rtc;
    localparam int DIV = 256;

    logic       clk_bus = 1'b0, clk_rtc = 1'b0, rst_n = 1'b0;
    logic       inc_sec = 1'b0, dec_sec = 1'b0;
    logic       bus_req = 1'b0, bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_ready;
    logic [7:0] bus_rdata;

    always #4  clk_bus = ~clk_bus;
    always #15 clk_rtc = ~clk_rtc;

    cal_rtc #(.TICK_DIV(DIV)) dut (
        .clk_rtc(clk_rtc), .clk_bus(clk_bus), .rst_n(rst_n),
        .inc_sec(inc_sec), .dec_sec(dec_sec),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
    );

    int  n_chk = 0, n_fail = 0;
    bit  done = 0;
    int  m[7] = '{0, 0, 0, 1, 1, 1, 0};   // live model: sec min hr dow dom mon yr
    int  o[7] = '{0, 0, 0, 1, 1, 1, 0};   // model of the read registers
    bit  incp = 0, decp = 0;
    int  rc = 0;
    event tick_ev;

    task automatic chk(string req, int got, int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int mdays(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic void adv();
        m[0]++;
        if (m[0] < 60) return;
        m[0] = 0; m[1]++;
        if (m[1] < 60) return;
        m[1] = 0; m[2]++;
        if (m[2] < 24) return;
        m[2] = 0;
        m[3] = (m[3] == 7) ? 1 : m[3] + 1;
        m[4]++;
        if (m[4] <= mdays(m[5], m[6])) return;
        m[4] = 1; m[5]++;
        if (m[5] <= 12) return;
        m[5] = 1;
        m[6] = (m[6] == 99) ? 0 : m[6] + 1;
    endfunction

    // Behavioural time base: a tick on every DIV-th crystal edge after reset.
    always @(posedge clk_rtc) begin
        if (rst_n) begin
            rc++;
            if (rc == DIV) begin
                rc = 0;
                if (incp && !decp) begin adv(); adv(); end
                else if (!(decp && !incp)) adv();
                incp = 0; decp = 0;
                -> tick_ev;
            end
        end
    end

    task automatic bus_rd(input int a, output int v);
        @(negedge clk_bus);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 3'(a);
        #1 chk("R5 read wait cycle", int'(bus_ready), 0);
        @(negedge clk_bus);
        chk("R5 read done", int'(bus_ready), 1);
        v = int'(bus_rdata);
        @(negedge clk_bus);
        bus_req = 1'b0;
    endtask

    task automatic bus_wr(input int a, input int dv);
        @(negedge clk_bus);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(dv);
        #1 chk("R5 write no wait", int'(bus_ready), 1);
        @(negedge clk_bus);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rtc_wait(input int n);
        repeat (n) @(negedge clk_rtc);
    endtask

    task automatic check_all(input string req);
        int v;
        bus_rd(0, v);
        for (int i = 0; i < 7; i++) o[i] = m[i];
        chk(req, v, o[0]);
        for (int i = 1; i < 7; i++) begin
            bus_rd(i, v);
            chk(req, v, o[i]);
        end
    endtask

    task automatic write_field(input int a, input int dv);
        bus_wr(7, 0);
        bus_wr(a, dv);
        m[a] = dv;
        rtc_wait(10);
    endtask

    task automatic fresh();
        @(tick_ev);
        rtc_wait(4);
    endtask

    task automatic settle();
        @(tick_ev);
        rtc_wait(20);
    endtask

    task automatic set_time(input int s, input int mi, input int h, input int dw,
                            input int dm, input int mo, input int y, input string req);
        fresh();
        write_field(6, y);  write_field(5, mo); write_field(4, dm);
        write_field(3, dw); write_field(2, h);  write_field(1, mi);
        write_field(0, s);
        check_all(req);
        settle();
        check_all(req);
    endtask

    task automatic pulse(input bit i, input bit dd);
        @(negedge clk_rtc);
        inc_sec = i; dec_sec = dd;
        if (i)  incp = 1;
        if (dd) decp = 1;
        rtc_wait(3);
        inc_sec = 1'b0; dec_sec = 1'b0;
        rtc_wait(2);
    endtask

    initial begin
        int a, b;
        #302 rst_n = 1'b1;

        // R3: reset values and idle bus
        repeat (3) @(negedge clk_bus);
        chk("R3 idle ready", int'(bus_ready), 0);
        check_all("R3");

        // R1: three ticks give three seconds; R4: repeated seconds reads agree
        repeat (3) @(tick_ev);
        rtc_wait(20);
        check_all("R1");
        bus_rd(0, a);
        bus_rd(0, b);
        chk("R4 repeat read", b, a);
        chk("R4 repeat value", a, m[0]);

        // R4: non-seconds registers keep the last snapshot
        fresh();
        write_field(0, 59);
        write_field(1, 5);
        check_all("R4");
        settle();
        bus_rd(1, a);
        chk("R4 stale minutes", a, o[1]);
        check_all("R4");

        // R6: gate required, survives reads, closes after one write
        fresh();
        bus_wr(1, 30);
        rtc_wait(10);
        check_all("R6 locked");
        bus_wr(7, 0);
        bus_rd(3, a);
        bus_rd(5, a);
        bus_wr(1, 30);
        m[1] = 30;
        rtc_wait(10);
        bus_wr(1, 31);
        rtc_wait(10);
        check_all("R6");

        // R7: second write while the first is in flight is dropped
        fresh();
        bus_wr(7, 0); bus_wr(2, 5);
        bus_wr(7, 0); bus_wr(2, 7);
        m[2] = 5;
        rtc_wait(10);
        check_all("R7");
        write_field(2, 9);
        check_all("R7 later");

        // R10: out-of-range values are ignored
        fresh();
        bus_wr(7, 0); bus_wr(0, 60);  rtc_wait(10);
        bus_wr(7, 0); bus_wr(3, 0);   rtc_wait(10);
        bus_wr(7, 0); bus_wr(5, 13);  rtc_wait(10);
        bus_wr(7, 0); bus_wr(6, 100); rtc_wait(10);
        check_all("R10");

        // R1: full cascade into a new century
        set_time(59, 59, 23, 7, 31, 12, 99, "R1 cascade");

        // R2: month lengths and leap years
        set_time(59, 59, 23, 3, 28, 2, 4, "R2 leap Feb 28");
        set_time(59, 59, 23, 3, 29, 2, 4, "R2 leap Feb 29");
        set_time(59, 59, 23, 3, 28, 2, 5, "R2 plain Feb 28");
        set_time(59, 59, 23, 3, 30, 4, 5, "R2 Apr 30");
        set_time(59, 59, 23, 3, 30, 1, 5, "R2 Jan 30");

        // R8: increment corrections
        fresh();
        pulse(1, 0);
        settle();
        check_all("R8");
        fresh();
        write_field(0, 58);
        pulse(1, 0);
        pulse(1, 0);
        settle();
        check_all("R8 carry once");

        // R9: decrement corrections and both together
        fresh();
        pulse(0, 1);
        settle();
        check_all("R9");
        fresh();
        write_field(0, 0);
        pulse(0, 1);
        settle();
        check_all("R9 at zero");
        fresh();
        pulse(1, 1);
        settle();
        check_all("R9 both");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk_bus);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule